// File: doc/BRIEF.md
# Direction-Aware Byte FIFO with Half-Level Interrupt

This block buffers bytes between a two-wire serial bus engine and the software or DMA side of a controller. Bytes enter through a valid/ready write port and leave through a valid/ready read port. When the controller receives, the bus engine fills the queue and software drains it. When it transmits, software fills the queue and the bus engine drains it.

A single half-level interrupt serves both directions, and its comparison flips with the direction. In receive mode it fires once enough data has built up to be worth draining. In transmit mode it fires while enough room exists to be worth refilling. The interrupt is gated by an enable bit and by a direction-valid input. This keeps it quiet while the transfer direction is still unknown.

The write side applies back-pressure through `wr_ready` when the queue is full. The read side offers data through `rd_valid` whenever the queue is not empty. A push happens on a cycle with `wr_valid && wr_ready`. A pop happens on a cycle with `rd_valid && rd_ready`. Attempts that are refused raise sticky error flags. Two control strobes empty the queue: a clear strobe and a controller-reset strobe. Only the controller-reset strobe also drops the interrupt enable.

Top module: `dirq_fifo`

## Requirements
- R1: After `rst_n` is released, the outputs are as follows: `fill_level` 0, `is_empty` 1, `is_full` 0, `wr_ready` 1, `rd_valid` 0, `ovf_flag` 0, `unf_flag` 0, `irq_en` 0 and `irq` 0.
- R2: Bytes leave the read port in the order they were accepted at the write port. `rd_data` shows the oldest byte whenever `rd_valid` is 1. `wr_ready` equals not full, and `rd_valid` equals not empty.
- R3: A write attempt while the queue is full is dropped, so the queue contents and level do not change. The attempt sets `ovf_flag`, and the flag stays set until a clear or controller reset.
- R4: A read attempt (`rd_ready` high) while the queue is empty changes nothing. The attempt sets `unf_flag`, and the flag stays set until a clear or controller reset.
- R5: An accepted push and an accepted pop in the same cycle leave `fill_level` unchanged.
- R6: With `dir_tx` 0 (receive), the threshold holds when `fill_level >= DEPTH/2`.
- R7: With `dir_tx` 1 (transmit), the threshold holds when `fill_level <= DEPTH/2`.
- R8: `irq` is combinational and equals threshold AND `irq_en` AND `dir_valid`. It follows a level change in the same cycle that `fill_level` changes.
- R9: `clr` empties the queue on the next edge and clears both error flags. It leaves `irq_en` alone. A push or pop in the same cycle is discarded.
- R10: `ctl_rst` empties the queue, clears both error flags and clears `irq_en` on the next edge. It takes priority over `clr` and over `ien_we`.
- R11: `ien_we` loads `ien_wdata` into `irq_en` on the next edge unless `ctl_rst` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Write byte offered |
| wr_ready | output | 1 | Queue can accept a byte |
| wr_data | input | WIDTH | Write byte |
| rd_valid | output | 1 | Oldest byte available |
| rd_ready | input | 1 | Consumer takes the byte |
| rd_data | output | WIDTH | Oldest byte |
| clr | input | 1 | Empty queue, clear flags |
| ctl_rst | input | 1 | Controller reset: empty queue, clear flags and enable |
| ien_we | input | 1 | Load interrupt enable |
| ien_wdata | input | 1 | New interrupt enable value |
| dir_tx | input | 1 | 0 receive, 1 transmit |
| dir_valid | input | 1 | Direction is settled |
| fill_level | output | CW | Number of stored bytes |
| is_full | output | 1 | Level equals DEPTH |
| is_empty | output | 1 | Level equals zero |
| ovf_flag | output | 1 | Sticky refused-write flag |
| unf_flag | output | 1 | Sticky refused-read flag |
| irq_en | output | 1 | Interrupt enable state |
| irq | output | 1 | Half-level interrupt |

## Verification
A pointer or counter that drifts shows up at `fill_level` one edge after the faulty operation. It then appears within a few pops as a byte out of order at `rd_data`. A threshold comparison that uses the wrong sense or an off-by-one edge shows as a wrong `irq` in the same cycle that the level reaches DEPTH/2. The bench therefore walks the level across the half mark in both directions. An enable or flag that fails to clear, or clears when it should not, is visible on the cycle after the strobe.

// File: rtl/dirq_pkg.sv
package dirq_pkg;
  typedef enum logic {XFER_RX = 1'b0, XFER_TX = 1'b1} xfer_dir_e;
  typedef enum logic [1:0] {OP_IDLE = 2'b00, OP_POP = 2'b01, OP_PUSH = 2'b10, OP_BOTH = 2'b11} fifo_op_e;
endpackage

// File: rtl/dirq_store.sv
module dirq_store #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/dirq_ctrl.sv
module dirq_ctrl
  import dirq_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          drop_all,
  input  logic          push_req,
  input  logic          pop_req,
  output logic          push_ok,
  output logic          pop_ok,
  output logic [AW-1:0] wr_ptr,
  output logic [AW-1:0] rd_ptr,
  output logic [CW-1:0] level,
  output logic          full,
  output logic          empty,
  output logic          ovf,
  output logic          unf
);
  localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);

  fifo_op_e op;

  assign full    = (level == FULL_LVL);
  assign empty   = (level == '0);
  assign push_ok = push_req && !full;
  assign pop_ok  = pop_req && !empty;
  assign op      = fifo_op_e'({push_ok, pop_ok});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
      ovf    <= 1'b0;
      unf    <= 1'b0;
    end else if (drop_all) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
      ovf    <= 1'b0;
      unf    <= 1'b0;
    end else begin
      if (push_ok) wr_ptr <= wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
      unique case (op)
        OP_PUSH: level <= level + 1'b1;
        OP_POP:  level <= level - 1'b1;
        default: level <= level;
      endcase
      if (push_req && full) ovf <= 1'b1;
      if (pop_req && empty) unf <= 1'b1;
    end
  end
endmodule

// File: rtl/dirq_thresh.sv
module dirq_thresh
  import dirq_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic [CW-1:0] level,
  input  xfer_dir_e     dir,
  output logic          hit
);
  localparam logic [CW-1:0] HALF = CW'(DEPTH / 2);

  always_comb begin
    unique case (dir)
      XFER_TX: hit = (level <= HALF);
      default: hit = (level >= HALF);
    endcase
  end
endmodule

// File: rtl/dirq_fifo.sv
module dirq_fifo
  import dirq_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int DEPTH = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [WIDTH-1:0] wr_data,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [WIDTH-1:0] rd_data,
  input  logic             clr,
  input  logic             ctl_rst,
  input  logic             ien_we,
  input  logic             ien_wdata,
  input  logic             dir_tx,
  input  logic             dir_valid,
  output logic [CW-1:0]    fill_level,
  output logic             is_full,
  output logic             is_empty,
  output logic             ovf_flag,
  output logic             unf_flag,
  output logic             irq_en,
  output logic             irq
);
  logic          push_ok, pop_ok, thr_hit, drop_all;
  logic [AW-1:0] wr_ptr, rd_ptr;

  assign drop_all = clr || ctl_rst;

  dirq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .drop_all (drop_all),
    .push_req (wr_valid),
    .pop_req  (rd_ready),
    .push_ok  (push_ok),
    .pop_ok   (pop_ok),
    .wr_ptr   (wr_ptr),
    .rd_ptr   (rd_ptr),
    .level    (fill_level),
    .full     (is_full),
    .empty    (is_empty),
    .ovf      (ovf_flag),
    .unf      (unf_flag)
  );

  dirq_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
    .clk   (clk),
    .we    (push_ok && !drop_all),
    .waddr (wr_ptr),
    .wdata (wr_data),
    .raddr (rd_ptr),
    .rdata (rd_data)
  );

  dirq_thresh #(.DEPTH(DEPTH)) u_thr (
    .level (fill_level),
    .dir   (xfer_dir_e'(dir_tx)),
    .hit   (thr_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       irq_en <= 1'b0;
    else if (ctl_rst) irq_en <= 1'b0;
    else if (ien_we)  irq_en <= ien_wdata;
  end

  assign wr_ready = !is_full;
  assign rd_valid = !is_empty;
  assign irq      = thr_hit && irq_en && dir_valid;
endmodule

// File: rtl/dirq_fifo_chk.sv
module dirq_fifo_chk #(
  parameter int DEPTH = 8,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_valid,
  input logic          wr_ready,
  input logic          rd_valid,
  input logic          rd_ready,
  input logic          clr,
  input logic          ctl_rst,
  input logic          ien_we,
  input logic          dir_tx,
  input logic          dir_valid,
  input logic [CW-1:0] fill_level,
  input logic          is_full,
  input logic          is_empty,
  input logic          ovf_flag,
  input logic          unf_flag,
  input logic          irq_en,
  input logic          irq
);
  localparam logic [CW-1:0] HALF = CW'(DEPTH / 2);

  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (is_full && wr_valid && !rd_ready && !clr && !ctl_rst) |=> $stable(fill_level)); // R3
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !clr && !ctl_rst) |=> ovf_flag); // R3
  AST_EMPTY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (is_empty && rd_ready && !wr_valid && !clr && !ctl_rst) |=> (is_empty && unf_flag)); // R4
  AST_RW_BALANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && rd_valid && rd_ready && !clr && !ctl_rst) |=> $stable(fill_level)); // R5
  AST_RX_THRESH: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en && dir_valid && !dir_tx && fill_level >= HALF) |-> irq); // R6
  AST_TX_THRESH: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en && dir_valid && dir_tx && fill_level <= HALF) |-> irq); // R7
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (irq_en && dir_valid)); // R8
  AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !ctl_rst && !ien_we) |=> (is_empty && !ovf_flag && !unf_flag && irq_en == $past(irq_en))); // R9
  AST_CTLRST_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rst |=> (is_empty && !irq_en && !ovf_flag && !unf_flag)); // R10
endmodule

bind dirq_fifo dirq_fifo_chk #(.DEPTH(DEPTH)) u_dirq_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_valid   (wr_valid),
  .wr_ready   (wr_ready),
  .rd_valid   (rd_valid),
  .rd_ready   (rd_ready),
  .clr        (clr),
  .ctl_rst    (ctl_rst),
  .ien_we     (ien_we),
  .dir_tx     (dir_tx),
  .dir_valid  (dir_valid),
  .fill_level (fill_level),
  .is_full    (is_full),
  .is_empty   (is_empty),
  .ovf_flag   (ovf_flag),
  .unf_flag   (unf_flag),
  .irq_en     (irq_en),
  .irq        (irq)
);

// File: tb/test_dirq_fifo.sv
module test_dirq_fifo;
  localparam int W = 8;
  localparam int D = 8;
  localparam int CW = $clog2(D) + 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_valid = 0, rd_ready = 0, clr = 0, ctl_rst = 0, ien_we = 0, ien_wdata = 0;
  logic dir_tx = 0, dir_valid = 0;
  logic [W-1:0] wr_data = '0;
  logic wr_ready, rd_valid, is_full, is_empty, ovf_flag, unf_flag, irq_en, irq;
  logic [W-1:0] rd_data;
  logic [CW-1:0] fill_level;

  int n_chk = 0, n_fail = 0;
  logic [W-1:0] q [$];
  bit m_ien = 0, m_ovf = 0, m_unf = 0;

  always #5 clk = ~clk;

  dirq_fifo #(.WIDTH(W), .DEPTH(D)) i_dirq_fifo (.*);

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic bit exp_irq(input int n, input bit tx, input bit dv, input bit en);
    return dv && en && (tx ? (n <= D/2) : (n >= D/2));
  endfunction

  task automatic check_state(input string tag);
    int n = q.size();
    check(tag, "level", int'(fill_level), n);
    check(tag, "full/ready", {is_full, wr_ready}, (n == D) ? 2 : 1);
    check(tag, "empty/valid", {is_empty, rd_valid}, (n == 0) ? 2 : 1);
    check(tag, "ovf", ovf_flag, m_ovf);
    check(tag, "unf", unf_flag, m_unf);
    check(tag, "ien", irq_en, m_ien);
    check(dir_valid && m_ien ? (dir_tx ? "R7" : "R6") : "R8", "irq", irq,
          exp_irq(n, dir_tx, dir_valid, m_ien));
  endtask

  // Called just after a falling edge; applies one cycle of stimulus.
  task automatic step(input bit iv, input logic [W-1:0] id, input bit rr, input bit c,
                      input bit cr, input bit iw, input bit iwd, input string tag);
    bit full_m, empty_m;
    wr_valid = iv; wr_data = id; rd_ready = rr; clr = c; ctl_rst = cr;
    ien_we = iw; ien_wdata = iwd;
    #1;
    full_m = (q.size() == D);
    empty_m = (q.size() == 0);
    if (!empty_m) check("R2", "rd_data", rd_data, q[0]);
    @(posedge clk);
    if (cr) begin
      q.delete(); m_ovf = 0; m_unf = 0; m_ien = 0;
    end else begin
      if (iw) m_ien = iwd;
      if (c) begin
        q.delete(); m_ovf = 0; m_unf = 0;
      end else begin
        if (iv && full_m) m_ovf = 1;
        if (rr && empty_m) m_unf = 1;
        if (rr && !empty_m) void'(q.pop_front());
        if (iv && !full_m) q.push_back(id);
      end
    end
    @(negedge clk);
    check_state(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_5678));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    dir_valid = 1;
    check_state("R1");
    check("R1", "irq after reset", irq, 0);
    // R11: enable the interrupt
    step(0, 0, 0, 0, 0, 1, 1, "R11");
    // R6: receive mode, fill past half, checking irq at every level
    dir_tx = 0;
    for (int i = 0; i < D; i++) step(1, W'(8'h10 + i), 0, 0, 0, 0, 0, "R6");
    // R3: write while full
    step(1, 8'hEE, 0, 0, 0, 0, 0, "R3");
    // R7: transmit mode while draining
    dir_tx = 1;
    step(0, 0, 0, 0, 0, 0, 0, "R7");
    // R5: push and pop together
    step(1, 8'hA5, 1, 0, 0, 0, 0, "R5");
    for (int i = 0; i < D; i++) step(0, 0, 1, 0, 0, 0, 0, "R2");
    // R4: read while empty
    step(0, 0, 1, 0, 0, 0, 0, "R4");
    // R8: direction not valid masks irq
    dir_valid = 0;
    step(0, 0, 0, 0, 0, 0, 0, "R8");
    dir_valid = 1;
    // R9: clear with data present keeps enable, with a discarded push
    step(1, 8'h01, 0, 0, 0, 0, 0, "R9");
    step(1, 8'h02, 0, 1, 0, 0, 0, "R9");
    check("R9", "ien kept", irq_en, 1);
    // R10: controller reset beats clear and enable write
    step(1, 8'h03, 0, 0, 0, 0, 0, "R10");
    step(1, 8'h04, 1, 1, 1, 1, 1, "R10");
    check("R10", "ien dropped", irq_en, 0);
    // Random traffic
    for (int i = 0; i < 4000; i++) begin
      int r = $urandom_range(0, 99);
      dir_tx = $urandom_range(0, 1);
      dir_valid = ($urandom_range(0, 7) != 0);
      step($urandom_range(0, 99) < 55, W'($urandom), $urandom_range(0, 99) < 45,
           r == 0, r == 1, r >= 2 && r < 6, $urandom_range(0, 3) != 0, "R2");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule